// File: doc/BRIEF.md
# UART Interrupt Enable and Identification

This block gathers the four interrupt conditions of a UART channel (receive data available, transmit holding register empty, receiver line status, modem status change) and combines them under a software-writable enable mask into a single interrupt output. Alongside the output it produces an identification byte that names the highest-priority enabled condition. Software reads this byte to decide which service routine to run.

Two of the conditions are latched inside the block. The transmit-empty condition is captured on the rising edge of the transmitter's "holding register empty" level. It is released when software reads the identification byte while that byte shows the transmit-empty code, or when software writes the holding register. The four modem delta flags are captured from single-cycle pulses and held until the modem status register is read. The receive-available and line-status conditions are levels owned by the receiver and are passed through as they are. The block also produces the power-down request, which is gated by two separate enable bits, and a polled-mode indication.

All pins are plain control and status signals. No data stream crosses the block, so there is no valid/ready handshake and no back-pressure. Register strobes are single-cycle pulses and take effect at the next rising clock edge.

Top module: `uirq_ctrl`

## Requirements
- R1: After reset the enable register reads 0x00. A write stores bit 0 (receive-available enable), bit 1 (transmit-empty enable), bit 2 (line-status enable), bit 3 (modem-change enable) and bit 5 (power-down enable), and these bits read back from the following cycle onward.
- R2: Enable bits 4, 6 and 7 always read 0, whatever was written.
- R3: `pd_active` is 1 only when enable bit 5 and `mcr_pd` are both 1.
- R4: After reset the identification byte reads 0x01 and `irq` is 0. Bit 0 of the byte is 1 exactly when no enabled condition is pending.
- R5: Identification bits 7 and 6 both equal `fifo_en`, and bits 5 and 4 read 0.
- R6: When `fifo_en` is 1 and enable bits 0 to 3 are all 0, `polled_mode` is 1, `irq` stays 0 and the identification byte shows nothing pending, even while conditions are active.
- R7: Identification bits 3:1 carry the code of the highest-priority enabled condition: line status 011 (byte 0x06), receive available 010 (0x04), transmit empty 001 (0x02), modem change 000 (0x00), in that order of priority. Masked conditions never appear.
- R8: A rising edge on `tx_empty` makes the transmit-empty condition pending. It clears on `thr_wr`, or on `iir_rd` while the byte shows code 001. A read that shows a different code leaves it pending.
- R9: Each bit of `modem_delta_in` pulsed high sets the matching bit of `msr_delta`. `msr_rd` clears all four bits, but a pulse in the same cycle still sets its bit. The modem-change condition is pending while any bit is set.
- R10: `irq` is 1 exactly when at least one enabled condition is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ier_wr | input | 1 | Enable register write strobe |
| wdata | input | 8 | Write data for the enable register |
| ier_rdata | output | 8 | Enable register read value |
| iir_rd | input | 1 | Identification register read strobe |
| iir_rdata | output | 8 | Identification register value |
| thr_wr | input | 1 | Transmit holding register write strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| fifo_en | input | 1 | FIFO mode is on |
| mcr_pd | input | 1 | Power-down bit of the modem control register |
| rx_avail | input | 1 | Receive data available level |
| line_err | input | 1 | Receiver line status condition level |
| tx_empty | input | 1 | Transmit holding register empty level |
| modem_delta_in | input | 4 | Modem line change pulses |
| msr_delta | output | 4 | Latched modem delta flags |
| irq | output | 1 | Interrupt output, active high |
| polled_mode | output | 1 | FIFO mode on with all interrupt enables off |
| pd_active | output | 1 | Power-down request |

## Verification
The bench builds the block with its default parameters: an 8-bit register width, four sources and four modem delta flags. With these values every identification code can be reached, the reserved enable bits can be driven at the ports, and each delta bit can be pulsed on its own. Directed scenarios stack all four conditions at once and then peel them off one at a time so that each priority step is observed. They read the identification byte while line status outranks transmit-empty, and they line up a delta pulse with a modem status read in the same cycle.

// File: rtl/uirq_pkg.sv
package uirq_pkg;
  // Priority ranks, 0 = highest
  localparam int unsigned NSRC      = 4;
  localparam int unsigned RANK_LINE = 0;
  localparam int unsigned RANK_RXD  = 1;
  localparam int unsigned RANK_TXE  = 2;
  localparam int unsigned RANK_MDM  = 3;

  // Enable-register bit positions (software-visible)
  localparam int unsigned EN_RXD  = 0;
  localparam int unsigned EN_TXE  = 1;
  localparam int unsigned EN_LINE = 2;
  localparam int unsigned EN_MDM  = 3;
  localparam int unsigned EN_PD   = 5;

  // Identification code of a rank: highest rank gets the largest code
  function automatic logic [2:0] rank_code(input int unsigned rank);
    return 3'(NSRC - 1 - rank);
  endfunction
endpackage

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MASK_W = 4,
  parameter int unsigned PD_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [MASK_W-1:0] mask,
  output logic              pd_en,
  output logic [DATA_W-1:0] rdata
);
  logic [MASK_W-1:0] mask_q;
  logic              pd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      pd_q   <= 1'b0;
    end else if (wr) begin
      mask_q <= wdata[MASK_W-1:0];
      pd_q   <= wdata[PD_BIT];
    end
  end

  always_comb begin
    rdata                = '0;
    rdata[MASK_W-1:0]    = mask_q;
    rdata[PD_BIT]        = pd_q;
  end

  assign mask  = mask_q;
  assign pd_en = pd_q;

  AST_IER_WRITE_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (rdata[MASK_W-1:0] == $past(wdata[MASK_W-1:0])) && (rdata[PD_BIT] == $past(wdata[PD_BIT]))); // R1
endmodule

// File: rtl/uirq_txe_latch.sv
module uirq_txe_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_empty,
  input  logic thr_wr,
  input  logic ack,
  output logic pend
);
  logic prev_q, pend_q, set_ev;

  assign set_ev = tx_empty & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= tx_empty;
      pend_q <= set_ev | (pend_q & ~(thr_wr | ack));
    end
  end

  assign pend = pend_q;

  AST_TXE_CLEARED_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !set_ev) |=> !pend); // R8
endmodule

// File: rtl/uirq_delta_latch.sv
module uirq_delta_latch #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pulse_in,
  input  logic         clr,
  output logic [W-1:0] flags
);
  logic [W-1:0] flags_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (clr ? '0 : flags_q) | pulse_in;
  end

  assign flags = flags_q;

  AST_DELTA_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && pulse_in == '0) |=> (flags == '0)); // R9
endmodule

// File: rtl/uirq_prio.sv
module uirq_prio #(
  parameter int unsigned N      = 4,
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      req,
  output logic [N-1:0]      grant,
  output logic              any,
  output logic [CODE_W-1:0] code
);
  logic [N:0] higher;

  assign higher[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_rank
    assign grant[i]    = req[i] & ~higher[i];
    assign higher[i+1] = higher[i] | req[i];
  end
  assign any = higher[N];

  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) code = CODE_W'(N - 1 - i);
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R7
  AST_GRANT_IFF_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |-> (grant != '0)); // R10
endmodule

// File: rtl/uirq_ctrl.sv
module uirq_ctrl #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned DELTA_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ier_wr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  ier_rdata,
  input  logic               iir_rd,
  output logic [DATA_W-1:0]  iir_rdata,
  input  logic               thr_wr,
  input  logic               msr_rd,
  input  logic               fifo_en,
  input  logic               mcr_pd,
  input  logic               rx_avail,
  input  logic               line_err,
  input  logic               tx_empty,
  input  logic [DELTA_W-1:0] modem_delta_in,
  output logic [DELTA_W-1:0] msr_delta,
  output logic               irq,
  output logic               polled_mode,
  output logic               pd_active
);
  import uirq_pkg::*;

  localparam int unsigned CODE_W = 3;
  localparam int unsigned MASK_W = NSRC;

  logic [MASK_W-1:0] mask;
  logic              pd_en;
  logic              txe_pend, txe_ack;
  logic [NSRC-1:0]   req, grant;
  logic              any;
  logic [CODE_W-1:0] code;

  uirq_enable_reg #(.DATA_W(DATA_W), .MASK_W(MASK_W), .PD_BIT(EN_PD)) u_en (
    .clk(clk), .rst_n(rst_n), .wr(ier_wr), .wdata(wdata),
    .mask(mask), .pd_en(pd_en), .rdata(ier_rdata)
  );

  uirq_txe_latch u_txe (
    .clk(clk), .rst_n(rst_n), .tx_empty(tx_empty), .thr_wr(thr_wr),
    .ack(txe_ack), .pend(txe_pend)
  );

  uirq_delta_latch #(.W(DELTA_W)) u_dlt (
    .clk(clk), .rst_n(rst_n), .pulse_in(modem_delta_in), .clr(msr_rd),
    .flags(msr_delta)
  );

  always_comb begin
    req            = '0;
    req[RANK_LINE] = line_err   & mask[EN_LINE];
    req[RANK_RXD]  = rx_avail   & mask[EN_RXD];
    req[RANK_TXE]  = txe_pend   & mask[EN_TXE];
    req[RANK_MDM]  = (|msr_delta) & mask[EN_MDM];
  end

  uirq_prio #(.N(NSRC), .CODE_W(CODE_W)) u_prio (
    .clk(clk), .rst_n(rst_n), .req(req), .grant(grant), .any(any), .code(code)
  );

  assign txe_ack     = iir_rd & grant[RANK_TXE];
  assign polled_mode = fifo_en & (mask == '0);
  assign irq         = any & ~polled_mode;
  assign pd_active   = pd_en & mcr_pd;

  always_comb begin
    iir_rdata                 = '0;
    iir_rdata[0]              = ~any;
    iir_rdata[CODE_W:1]       = code;
    iir_rdata[DATA_W-1]       = fifo_en;
    iir_rdata[DATA_W-2]       = fifo_en;
  end

  AST_IRQ_SHOWS_IN_IIR: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !iir_rdata[0]); // R10
  AST_POLLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    polled_mode |-> (!irq && iir_rdata[0])); // R6
  AST_PD_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    pd_active |-> (mcr_pd && ier_rdata[EN_PD])); // R3
  AST_TXE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (iir_rd && iir_rdata[3:1] == 3'b001 && !iir_rdata[0] && !(tx_empty && !$past(tx_empty)))
      |=> !u_txe.pend); // R8
endmodule

// File: tb/uirq_ctrl_bench.sv
module uirq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ier_wr = 0, iir_rd = 0, thr_wr = 0, msr_rd = 0;
  logic [7:0] wdata = '0;
  logic       fifo_en = 0, mcr_pd = 0, rx_avail = 0, line_err = 0, tx_empty = 1;
  logic [3:0] modem_delta_in = '0;
  logic [7:0] ier_rdata, iir_rdata;
  logic [3:0] msr_delta;
  logic       irq, polled_mode, pd_active;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  uirq_ctrl u_uirq_ctrl (
    .clk(clk), .rst_n(rst_n), .ier_wr(ier_wr), .wdata(wdata), .ier_rdata(ier_rdata),
    .iir_rd(iir_rd), .iir_rdata(iir_rdata), .thr_wr(thr_wr), .msr_rd(msr_rd),
    .fifo_en(fifo_en), .mcr_pd(mcr_pd), .rx_avail(rx_avail), .line_err(line_err),
    .tx_empty(tx_empty), .modem_delta_in(modem_delta_in), .msr_delta(msr_delta),
    .irq(irq), .polled_mode(polled_mode), .pd_active(pd_active)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic write_ier(input logic [7:0] v);
    @(negedge clk); ier_wr = 1; wdata = v;
    @(negedge clk); ier_wr = 0;
  endtask

  task automatic tx_edge();
    @(negedge clk); tx_empty = 0;
    @(negedge clk); tx_empty = 1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R4 iir after reset", iir_rdata, 8'h01);
    chk("R4 irq after reset", {7'b0, irq}, 8'h00);
    chk("R1 ier after reset", ier_rdata, 8'h00);
  endtask

  task automatic t_ier_bits();
    write_ier(8'hFF);
    chk("R2 reserved bits read 0", ier_rdata, 8'h2F);
    write_ier(8'h05);
    chk("R1 ier readback", ier_rdata, 8'h05);
    write_ier(8'h00);
  endtask

  task automatic t_power_down();
    write_ier(8'h20);
    #1 chk("R3 pd with mcr_pd=0", {7'b0, pd_active}, 8'h00);
    @(negedge clk); mcr_pd = 1; #1;
    chk("R3 pd with both set", {7'b0, pd_active}, 8'h01);
    write_ier(8'h00);
    #1 chk("R3 pd with ier bit clear", {7'b0, pd_active}, 8'h00);
    mcr_pd = 0;
  endtask

  task automatic t_fifo_polled();
    @(negedge clk); fifo_en = 1; rx_avail = 1; line_err = 1; #1;
    chk("R5 fifo bits", iir_rdata, 8'hC1);
    chk("R6 polled flag", {7'b0, polled_mode}, 8'h01);
    chk("R6 irq quiet", {7'b0, irq}, 8'h00);
    write_ier(8'h01);
    chk("R5 fifo bits with rx pending", iir_rdata, 8'hC4);
    chk("R6 polled flag off", {7'b0, polled_mode}, 8'h00);
    write_ier(8'h00);
    @(negedge clk); fifo_en = 0; rx_avail = 0; line_err = 0; #1;
    chk("R5 fifo off", iir_rdata, 8'h01);
  endtask

  task automatic t_priority();
    write_ier(8'h0F);
    @(negedge clk); modem_delta_in = 4'b0010;
    @(negedge clk); modem_delta_in = 4'b0000;
    chk("R7 modem alone", iir_rdata, 8'h00);
    chk("R10 irq with modem", {7'b0, irq}, 8'h01);
    tx_edge();
    chk("R7 tx over modem", iir_rdata, 8'h02);
    @(negedge clk); rx_avail = 1; line_err = 1; #1;
    chk("R7 line highest", iir_rdata, 8'h06);
    @(negedge clk); line_err = 0; #1;
    chk("R7 rx next", iir_rdata, 8'h04);
    @(negedge clk); rx_avail = 0; #1;
    chk("R7 tx next", iir_rdata, 8'h02);
    @(negedge clk); iir_rd = 1;
    @(negedge clk); iir_rd = 0;
    chk("R8 read clears tx", iir_rdata, 8'h00);
    @(negedge clk); msr_rd = 1;
    @(negedge clk); msr_rd = 0;
    chk("R9 msr read clears", iir_rdata, 8'h01);
    chk("R10 irq idle", {7'b0, irq}, 8'h00);
    write_ier(8'h00);
  endtask

  task automatic t_mask();
    write_ier(8'h02);
    @(negedge clk); line_err = 1; rx_avail = 1; #1;
    chk("R7 masked line", iir_rdata, 8'h01);
    chk("R10 masked irq", {7'b0, irq}, 8'h00);
    tx_edge();
    chk("R7 only tx", iir_rdata, 8'h02);
    @(negedge clk); thr_wr = 1;
    @(negedge clk); thr_wr = 0; line_err = 0; rx_avail = 0;
    chk("R8 thr write clears", iir_rdata, 8'h01);
    write_ier(8'h00);
  endtask

  task automatic t_tx_read_other();
    write_ier(8'h06);
    tx_edge();
    @(negedge clk); line_err = 1; #1;
    chk("R8 line shown", iir_rdata, 8'h06);
    @(negedge clk); iir_rd = 1;
    @(negedge clk); iir_rd = 0; line_err = 0; #1;
    chk("R8 tx kept after other read", iir_rdata, 8'h02);
    @(negedge clk); thr_wr = 1;
    @(negedge clk); thr_wr = 0;
    chk("R8 cleared", iir_rdata, 8'h01);
    write_ier(8'h00);
  endtask

  task automatic t_modem_flags();
    @(negedge clk); modem_delta_in = 4'b0101;
    @(negedge clk); modem_delta_in = 4'b0000;
    chk("R9 flags latched", {4'b0, msr_delta}, 8'h05);
    @(negedge clk); msr_rd = 1; modem_delta_in = 4'b1000;
    @(negedge clk); msr_rd = 0; modem_delta_in = 4'b0000;
    chk("R9 pulse wins over read", {4'b0, msr_delta}, 8'h08);
    @(negedge clk); msr_rd = 1;
    @(negedge clk); msr_rd = 0;
    chk("R9 read clears", {4'b0, msr_delta}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ier_bits();
    t_power_down();
    t_fifo_polled();
    t_priority();
    t_mask();
    t_tx_read_other();
    t_modem_flags();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule